// File: doc/BRIEF.md
# Isolated memory region access filter

This block sits in front of system memory and judges every transaction against a bank of eight programmable protected windows. Each window has an inclusive lower and upper bound at 1 KiB granularity, an enable flag, a lock flag, and two 32-bit permission masks: one for reads and one for writes. Each bit of a mask stands for one class of requesting agent. A request carries an address, a direction and a one-hot agent identifier. The block answers one cycle later with allow or deny. A denied access does not produce a bus error. It raises a sticky reset request for the whole system instead.

Software sets up the windows through a simple word-addressed register port. The window registers start at offset 0x40, and each window uses four words. Firmware can lock a window so that it cannot be changed until the next reset. Windows that are not locked can be reprogrammed or disabled at any time. The snoop agent class only ever writes, so the read mask has no place to grant it access.

Top module: `memguard_filter`

## Requirements
- R1: After reset every window is disabled and unlocked, and all of its register words read zero. rsp_valid and viol_reset are low.
- R2: Window n occupies byte offsets 0x40+16n (low word), +4 (high word), +8 (read mask) and +0xC (write mask). In the low word, bit 31 is lock, bit 30 is enable, and bits 21:0 hold address bits 31:10. The high word holds address bits 31:10 in bits 21:0. Other bits of both words read 0. Offsets outside 0x40..0xBF, and offsets not aligned to a word, read 0 and ignore writes.
- R3: An enabled window matches a request when low ≤ addr[31:10] ≤ high. Address bits 9:0 play no part. Disabled windows never match. A request that no window matches is allowed.
- R4: A read is checked against the read mask and a write against the write mask. The access is allowed only if the requesting agent's bit is set in every matching window's mask for that direction. Agent bits: 0 CPU normal mode, 1 CPU management mode, 8..11 virtual channel 0 sub-IDs 0..3, 12..15 virtual channel 1 sub-IDs 0..3, 29 RMU, 30 snoop, 31 on-chip SRAM flush.
- R5: Bit 30 of every read mask always reads 0, and writing a 1 there has no effect. A snoop-agent read inside any enabled window is therefore denied. Write-mask bit 30 is stored normally, so a snoop write can be granted.
- R6: A request presented with req_valid in one cycle gets rsp_valid and rsp_allow in the next cycle. A new request may be presented in every cycle. No response appears without a request.
- R7: A denied request sets viol_reset in the same cycle as its response. viol_reset then stays high until reset.
- R8: While a window's lock bit is set, writes to all four of its words are ignored, including attempts to clear the lock. Only reset clears the lock. Other windows remain writable.
- R9: When windows overlap, a denial by any one matching window denies the access, even if other matching windows permit it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| req_valid | input | 1 | Memory request present |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_agent | input | 32 | One-hot agent class of the requester |
| rsp_valid | output | 1 | Decision valid, one cycle after the request |
| rsp_allow | output | 1 | 1 = access allowed |
| viol_reset | output | 1 | Sticky system reset request after a denial |

## Verification
The hardest case to reach is one that needs several windows at once: a request that falls where two or three enabled windows overlap, and that one of them denies while the others allow. The stimulus sets up nested windows with different masks. It then sends, back to back, requests that land in the shared page and in the page that only one window covers. Because viol_reset is sticky, every denial test in a phase runs after all of that phase's allow tests. A reset between phases re-opens the check that viol_reset stays low. Locking is reached by writing the bounds and masks first and the lock word last. The bench then tries to overwrite each word and to clear the lock, and reads the values back.

// File: rtl/memguard_pkg.sv
package memguard_pkg;

   // Word select inside one window's four-word register group
   typedef enum logic [1:0] {
      W_LOW   = 2'd0,
      W_HIGH  = 2'd1,
      W_RMASK = 2'd2,
      W_WMASK = 2'd3
   } word_e;

   // Control bits in the low word
   localparam int LOCK_BIT  = 31;
   localparam int EN_BIT    = 30;

   // Agent class that may only write
   localparam int SNOOP_BIT = 30;

endpackage

// File: rtl/memguard_region.sv
module memguard_region
   import memguard_pkg::*;
#(
   parameter int DATA_W           = 32,
   parameter int PAGE_W           = 22,
   parameter bit SNOOP_WRITE_ONLY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr_en,
   input  word_e             word,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              en_o,
   output logic [PAGE_W-1:0] lo_o,
   output logic [PAGE_W-1:0] hi_o,
   output logic [DATA_W-1:0] rmask_o,
   output logic [DATA_W-1:0] wmask_o
);

   logic              lock_q, en_q;
   logic [PAGE_W-1:0] lo_q, hi_q;
   logic [DATA_W-1:0] rmask_q, wmask_q;
   logic [DATA_W-1:0] rd_keep;

   generate
      if (SNOOP_WRITE_ONLY) begin : g_snoop_wo
         assign rd_keep = ~(DATA_W'(1) << SNOOP_BIT);
      end else begin : g_snoop_rw
         assign rd_keep = '1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_q  <= 1'b0;
         en_q    <= 1'b0;
         lo_q    <= '0;
         hi_q    <= '0;
         rmask_q <= '0;
         wmask_q <= '0;
      end else if (sel && wr_en && !lock_q) begin
         case (word)
            W_LOW: begin
               lock_q <= wdata[LOCK_BIT];
               en_q   <= wdata[EN_BIT];
               lo_q   <= wdata[PAGE_W-1:0];
            end
            W_HIGH:  hi_q    <= wdata[PAGE_W-1:0];
            W_RMASK: rmask_q <= wdata & rd_keep;
            default: wmask_q <= wdata;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      case (word)
         W_LOW: begin
            rdata[LOCK_BIT]     = lock_q;
            rdata[EN_BIT]       = en_q;
            rdata[PAGE_W-1:0]   = lo_q;
         end
         W_HIGH:  rdata[PAGE_W-1:0] = hi_q;
         W_RMASK: rdata = rmask_q;
         default: rdata = wmask_q;
      endcase
   end

   assign en_o    = en_q;
   assign lo_o    = lo_q;
   assign hi_o    = hi_q;
   assign rmask_o = rmask_q;
   assign wmask_o = wmask_q;

   AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> (lock_q && $stable(en_q) && $stable(lo_q) && $stable(hi_q)
                  && $stable(rmask_q) && $stable(wmask_q))); // R8

endmodule

// File: rtl/memguard_match.sv
module memguard_match #(
   parameter int DATA_W = 32,
   parameter int PAGE_W = 22
) (
   input  logic [PAGE_W-1:0] page,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_agent,
   input  logic              en,
   input  logic [PAGE_W-1:0] lo,
   input  logic [PAGE_W-1:0] hi,
   input  logic [DATA_W-1:0] rmask,
   input  logic [DATA_W-1:0] wmask,
   output logic              hit,
   output logic              permit
);

   logic [DATA_W-1:0] dir_mask;

   always_comb begin
      dir_mask = req_write ? wmask : rmask;
      hit      = en && (page >= lo) && (page <= hi);
      permit   = |(dir_mask & req_agent);
   end

endmodule

// File: rtl/memguard_verdict.sv
module memguard_verdict #(
   parameter int NUM_REGIONS = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic [NUM_REGIONS-1:0] hit,
   input  logic [NUM_REGIONS-1:0] permit,
   output logic                   rsp_valid,
   output logic                   rsp_allow,
   output logic                   viol
);

   logic deny;

   assign deny = |(hit & ~permit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_allow <= 1'b0;
         viol      <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         rsp_allow <= req_valid && !deny;
         if (req_valid && deny) viol <= 1'b1;
      end
   end

   AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R6
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R6
   AST_MISS_ALLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (hit == '0)) |=> rsp_allow); // R3
   AST_DENY_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_allow) |-> viol); // R7
   AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      viol |=> viol); // R7

endmodule

// File: rtl/memguard_filter.sv
module memguard_filter
   import memguard_pkg::*;
#(
   parameter int NUM_REGIONS      = 8,
   parameter int ADDR_W           = 32,
   parameter int DATA_W           = 32,
   parameter int GRAN_LOG2        = 10,
   parameter int CFG_AW           = 8,
   parameter int REG_BASE         = 'h40,
   parameter bit SNOOP_WRITE_ONLY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_agent,
   output logic              rsp_valid,
   output logic              rsp_allow,
   output logic              viol_reset
);

   localparam int PAGE_W = ADDR_W - GRAN_LOG2;
   localparam int IDX_W  = $clog2(NUM_REGIONS);
   localparam int SPAN   = 16 * NUM_REGIONS;

   // Elaboration-time parameter checks
   generate
      if (NUM_REGIONS < 2) begin : g_bad_num
         $error("NUM_REGIONS must be at least 2");
      end
      if (PAGE_W < 1 || PAGE_W > EN_BIT) begin : g_bad_page
         $error("page field must fit below the control bits");
      end
      if (DATA_W <= LOCK_BIT) begin : g_bad_data
         $error("DATA_W too narrow for control bits");
      end
      if ((REG_BASE % 16) != 0 || REG_BASE + SPAN > (1 << CFG_AW)) begin : g_bad_base
         $error("register window misaligned or outside the config space");
      end
      if (CFG_AW < IDX_W + 4) begin : g_bad_cfg
         $error("CFG_AW too narrow to index all windows");
      end
   endgenerate

   // Register decode
   logic [CFG_AW-1:0] off;
   logic              in_window;
   logic [IDX_W-1:0]  idx;
   word_e             word;

   assign off       = cfg_addr - CFG_AW'(REG_BASE);
   assign in_window = (int'(cfg_addr) >= REG_BASE) && (int'(off) < SPAN) && (off[1:0] == 2'b00);
   assign idx       = off[IDX_W+3:4];
   assign word      = word_e'(off[3:2]);

   logic [PAGE_W-1:0] page;
   logic [GRAN_LOG2-1:0] unused_offset;
   assign page          = req_addr[ADDR_W-1:GRAN_LOG2];
   assign unused_offset = req_addr[GRAN_LOG2-1:0];

   logic [DATA_W-1:0]      rd_word [NUM_REGIONS];
   logic [NUM_REGIONS-1:0] hit, permit;

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
      logic              sel;
      logic              en;
      logic [PAGE_W-1:0] lo, hi;
      logic [DATA_W-1:0] rmask, wmask;

      assign sel = in_window && (idx == IDX_W'(g));

      memguard_region #(
         .DATA_W           (DATA_W),
         .PAGE_W           (PAGE_W),
         .SNOOP_WRITE_ONLY (SNOOP_WRITE_ONLY)
      ) u_region (
         .clk     (clk),
         .rst_n   (rst_n),
         .sel     (sel),
         .wr_en   (cfg_we),
         .word    (word),
         .wdata   (cfg_wdata),
         .rdata   (rd_word[g]),
         .en_o    (en),
         .lo_o    (lo),
         .hi_o    (hi),
         .rmask_o (rmask),
         .wmask_o (wmask)
      );

      memguard_match #(
         .DATA_W (DATA_W),
         .PAGE_W (PAGE_W)
      ) u_match (
         .page      (page),
         .req_write (req_write),
         .req_agent (req_agent),
         .en        (en),
         .lo        (lo),
         .hi        (hi),
         .rmask     (rmask),
         .wmask     (wmask),
         .hit       (hit[g]),
         .permit    (permit[g])
      );
   end

   assign cfg_rdata = in_window ? rd_word[idx] : '0;

   memguard_verdict #(
      .NUM_REGIONS (NUM_REGIONS)
   ) u_verdict (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .hit       (hit),
      .permit    (permit),
      .rsp_valid (rsp_valid),
      .rsp_allow (rsp_allow),
      .viol      (viol_reset)
   );

endmodule

// File: tb/memguard_filter_test.sv
`timescale 1ns/1ps
module memguard_filter_test;

   localparam logic [31:0] A_CPU   = 32'h0000_0001;
   localparam logic [31:0] A_SMM   = 32'h0000_0002;
   localparam logic [31:0] A_VC0   = 32'h0000_0100;
   localparam logic [31:0] A_VC1   = 32'h0000_1000;
   localparam logic [31:0] A_RMU   = 32'h2000_0000;
   localparam logic [31:0] A_SNOOP = 32'h4000_0000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [7:0]  cfg_addr;
   logic [31:0] cfg_wdata, cfg_rdata;
   logic        req_valid, req_write;
   logic [31:0] req_addr, req_agent;
   logic        rsp_valid, rsp_allow, viol_reset;

   always #2.5 clk = ~clk;

   memguard_filter uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_addr   (cfg_addr),
      .cfg_wdata  (cfg_wdata),
      .cfg_rdata  (cfg_rdata),
      .req_valid  (req_valid),
      .req_addr   (req_addr),
      .req_write  (req_write),
      .req_agent  (req_agent),
      .rsp_valid  (rsp_valid),
      .rsp_allow  (rsp_allow),
      .viol_reset (viol_reset)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Reference model of the window registers, built from the requirements
   logic        m_lk [8];
   logic        m_en [8];
   logic [21:0] m_lo [8];
   logic [21:0] m_hi [8];
   logic [31:0] m_rm [8];
   logic [31:0] m_wm [8];
   logic        exp_viol;

   function automatic void model_clear();
      for (int n = 0; n < 8; n++) begin
         m_lk[n] = 0; m_en[n] = 0; m_lo[n] = '0; m_hi[n] = '0; m_rm[n] = '0; m_wm[n] = '0;
      end
      exp_viol = 1'b0;
   endfunction

   function automatic logic exp_allow(logic [31:0] a, logic wr, logic [31:0] ag);
      logic ok = 1'b1;
      for (int n = 0; n < 8; n++) begin
         if (m_en[n] && m_lo[n] <= a[31:10] && a[31:10] <= m_hi[n]) begin
            if (((wr ? m_wm[n] : m_rm[n]) & ag) == '0) ok = 1'b0;
         end
      end
      return ok;
   endfunction

   // Scoreboard
   typedef struct {
      logic  allow;
      string tag;
   } item_t;
   item_t sb[$];

   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (sb.size() == 0) begin
            chk("R6 response without request", 32'(rsp_valid), 32'h0);
         end else begin
            item_t it;
            it = sb.pop_front();
            chk(it.tag, 32'(rsp_allow), 32'(it.allow));
         end
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cfg_we = 0; req_valid = 0;
      model_clear();
      sb.delete();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic cfg_wr(logic [7:0] a, logic [31:0] d);
      int n;
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      if (a >= 8'h40 && a < 8'hC0 && a[1:0] == 2'b00) begin
         n = (int'(a) - 'h40) >> 4;
         if (!m_lk[n]) begin
            case (a[3:2])
               2'd0: begin m_lk[n] = d[31]; m_en[n] = d[30]; m_lo[n] = d[21:0]; end
               2'd1: m_hi[n] = d[21:0];
               2'd2: m_rm[n] = d & 32'hBFFF_FFFF;
               default: m_wm[n] = d;
            endcase
         end
      end
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_chk(logic [7:0] a, logic [31:0] exp, string tag);
      cfg_addr = a;
      #1;
      chk(tag, cfg_rdata, exp);
   endtask

   task automatic req(logic [31:0] a, logic wr, logic [31:0] ag, string tag);
      item_t it;
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = wr; req_agent = ag;
      it.allow = exp_allow(a, wr, ag);
      it.tag   = tag;
      if (!it.allow) exp_viol = 1'b1;
      sb.push_back(it);
   endtask

   task automatic req_end();
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      #1;
      chk("R6 all responses received", 32'(sb.size()), 32'h0);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R6 watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
      req_valid = 0; req_write = 0; req_addr = '0; req_agent = '0;
      model_clear();
      do_reset();

      // R1 reset state
      chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'h0);
      chk("R1 viol_reset after reset", 32'(viol_reset), 32'h0);
      cfg_chk(8'h40, 32'h0, "R1 window0 low after reset");
      cfg_chk(8'hBC, 32'h0, "R1 window7 wmask after reset");

      // R2 register map
      cfg_wr(8'h40, 32'h4000_0100);
      cfg_wr(8'h44, 32'hFFC0_0103);
      cfg_wr(8'h48, A_CPU);
      cfg_wr(8'h4C, A_CPU | A_VC0);
      cfg_chk(8'h40, 32'h4000_0100, "R2 window0 low readback");
      cfg_chk(8'h44, 32'h0000_0103, "R2 window0 high readback, upper bits zero");
      cfg_chk(8'h4C, 32'h0000_0101, "R2 window0 wmask readback");
      cfg_wr(8'h00, 32'hFFFF_FFFF);
      cfg_chk(8'h00, 32'h0, "R2 unmapped offset reads zero");
      cfg_wr(8'h41, 32'h0);
      cfg_chk(8'h40, 32'h4000_0100, "R2 misaligned write ignored");
      cfg_chk(8'hC0, 32'h0, "R2 offset past last window reads zero");

      // R5 read mask snoop bit; window1 disabled but covering all
      cfg_wr(8'h54, 32'h003F_FFFF);
      cfg_wr(8'h58, 32'hFFFF_FFFF);
      cfg_chk(8'h58, 32'hBFFF_FFFF, "R5 read mask bit 30 forced clear");

      // R3 R4 R6 allowed accesses, back to back
      req(32'h0003_FFFF, 1'b0, A_RMU, "R3 below low bound allowed");
      req(32'h0004_0000, 1'b0, A_CPU, "R4 CPU read at low bound allowed");
      req(32'h0004_0FFF, 1'b1, A_CPU, "R3 inclusive high bound write allowed");
      req(32'h0004_1000, 1'b1, A_RMU, "R3 above high bound allowed");
      req(32'h0004_0800, 1'b1, A_VC0, "R4 VC0 write allowed by wmask");
      req(32'h0000_0100, 1'b1, A_RMU, "R3 disabled window ignored");
      req_end();
      chk("R7 no violation after allowed traffic", 32'(viol_reset), 32'(exp_viol));

      // R4 R7 denials
      req(32'h0004_0400, 1'b0, A_VC0, "R4 VC0 read denied by rmask");
      req(32'h0004_0000, 1'b1, A_SMM, "R4 SMM write denied");
      req(32'h0000_0000, 1'b0, A_CPU, "R3 miss after denial still allowed");
      req_end();
      chk("R7 violation raised", 32'(viol_reset), 32'h1);
      repeat (3) @(negedge clk);
      chk("R7 violation sticky", 32'(viol_reset), 32'h1);

      do_reset();
      chk("R1 reset clears violation", 32'(viol_reset), 32'h0);
      cfg_chk(8'h40, 32'h0, "R1 reset clears window0");

      // R5 R9 overlapping windows
      cfg_wr(8'h60, 32'h4000_0000); cfg_wr(8'h64, 32'h0);
      cfg_wr(8'h68, 32'hFFFF_FFFF); cfg_wr(8'h6C, 32'hFFFF_FFFF);
      cfg_wr(8'h70, 32'h4000_0000); cfg_wr(8'h74, 32'h1);
      cfg_wr(8'h78, 32'hFFFF_FFFF); cfg_wr(8'h7C, 32'hFFFF_FFFF);
      cfg_wr(8'h80, 32'h4000_0001); cfg_wr(8'h84, 32'h1);
      cfg_wr(8'h88, A_CPU);         cfg_wr(8'h8C, A_CPU);
      req(32'h0000_0100, 1'b1, A_SNOOP, "R5 snoop write allowed");
      req(32'h0000_0200, 1'b0, A_VC1, "R9 two permissive windows allow");
      req(32'h0000_0500, 1'b0, A_CPU, "R9 all overlapping permit CPU");
      req_end();
      chk("R7 no violation before denials", 32'(viol_reset), 32'h0);
      req(32'h0000_0100, 1'b0, A_SNOOP, "R5 snoop read denied");
      req(32'h0000_0500, 1'b0, A_VC1, "R9 one denying window wins");
      req_end();
      chk("R7 violation after overlap denial", 32'(viol_reset), 32'h1);

      // R8 lock
      cfg_wr(8'h94, 32'h20);
      cfg_wr(8'h98, A_CPU);
      cfg_wr(8'h9C, A_CPU);
      cfg_wr(8'h90, 32'hC000_0010);
      cfg_wr(8'h94, 32'h3FF);
      cfg_wr(8'h98, 32'hFFFF_FFFF);
      cfg_wr(8'h90, 32'h0);
      cfg_chk(8'h90, 32'hC000_0010, "R8 locked low word unchanged");
      cfg_chk(8'h94, 32'h0000_0020, "R8 locked high word unchanged");
      cfg_chk(8'h98, A_CPU, "R8 locked read mask unchanged");
      cfg_wr(8'hA8, 32'h55);
      cfg_chk(8'hA8, 32'h55, "R8 other window still writable");
      req(32'h0000_4800, 1'b0, A_RMU, "R8 locked window still enforces");
      req(32'h0000_4800, 1'b0, A_CPU, "R8 locked window permits CPU");
      req_end();

      do_reset();
      cfg_chk(8'h90, 32'h0, "R8 reset clears lock");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule